// File: doc/BRIEF.md
# Two-Level Translation Buffer with Shared-Size Sets and Per-Entry-Size Slots

This block keeps virtual-to-physical mapping entries in two storage regions that sit behind one flat index space. The lower region is set-associative (WAYS ways by SETS sets). Every entry in it uses the single page size given on `shared_ps`. The upper region holds FA_N fully associative slots, and each slot stores its own page size. An entry carries a virtual page-pair number (address bits 13 and up), an address-space tag, an exists flag, and two low words, one for the even page and one for the odd page. Bit 6 of the even low word is the global flag. In region one the page size is the shared one; in region two it is the slot's own field.

A controller issues one operation at a time by raising `op_valid` together with an operation code and its operands. The operations are: search by address, read by index, write by index, fill at a pseudo-random position, clear by index zone, and five invalidate variants. Each of these five picks entries by global flag, by tag or by page. The block takes an operation only in its idle state. All storage changes happen at that accept edge. `done` pulses in the following cycle, and the result ports hold values that stay stable until the next operation is accepted.

The controller has two states. ST_IDLE moves to ST_DONE on the transition "accept" when `op_valid` is high. With no request it stays in ST_IDLE ("wait"). ST_DONE always returns to ST_IDLE ("retire"). A free-running 16-bit LFSR picks the way or slot used by a fill.

Top module: `hyb_tlb`

## Requirements
- R1: After reset no entry exists: `done` is low, a search (op code 0) reports a miss, and a read (op code 1) of any index reports not-exist.
- R2: A search hits an entry only when all three of these hold: the entry exists; its global flag (even low word bit 6) is set or its tag equals `cur_asid`; and the address bits from (page size + 1) upward equal those of the stored page-pair number placed at bit 13.
- R3: A search returns the lowest flat index among hits. The set-associative index is way×SETS+set. Slot k of the fully associative region has index WAYS×SETS+k. So the set region wins over the slot region, and within a set the lower way wins.
- R4: In the set region a search looks only at set (address >> (`shared_ps`+1)) mod SETS, using `shared_ps`. Slots compare with their own stored size.
- R5: A write (op code 2) to an index below the entry count does one of two things. With `op_ne`=0 it stores address bits 13 and up, `cur_asid` and both low words, and sets exists; the size field is stored only for slot-region indices. With `op_ne`=1 it only clears exists.
- R6: A read of an absent entry returns `res_ne`=1 with tag, entry-high, both low words and size all zero. A read of a present entry returns `res_ne`=0, the stored words and tag, entry-high equal to the page-pair number shifted up by 13, and size equal to the slot's own size or, in the set region, `shared_ps`.
- R7: A fill (op code 3) writes like R5. When `op_ps` equals `shared_ps` it goes to a pseudo-random way of the address-derived set. Otherwise it goes to a pseudo-random slot. `res_index` reports the chosen index.
- R8: A clear (op code 4) with a set-region index affects only that index's set, across all ways. With a slot-region index it affects all slots. With any larger index it affects nothing. Only non-global entries tagged `cur_asid` lose exists.
- R9: Invalidate-all (op code 5) removes every entry.
- R10: Invalidate-by-global (op code 6) removes entries whose global flag equals `op_g`.
- R11: Invalidate-by-tag (op code 7) removes non-global entries whose tag equals `op_asid`, which is 10 bits wide.
- R12: Invalidate-page-tag (op code 8) removes existing non-global entries that are tagged `op_asid` and whose page matches `op_va` at the entry's page size.
- R13: Invalidate-page-tag-or-global (op code 9) removes existing entries that are global or tagged `op_asid` and whose page matches `op_va`.
- R14: An operation is accepted only in ST_IDLE. `done` is high for exactly the one cycle after acceptance, and `op_valid` during that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 4 | Operation code (0..9) |
| op_index | input | IDX_W | Flat index for read, write and clear |
| op_va | input | VA_W | Virtual address operand |
| op_ps | input | PS_W | Page size for write and fill |
| op_ne | input | 1 | Write removes the entry instead of loading it |
| op_lo0 | input | LO_W | Even-page low word |
| op_lo1 | input | LO_W | Odd-page low word |
| op_asid | input | ASID_W | Tag operand of the invalidates |
| op_g | input | 1 | Global value for invalidate-by-global |
| cur_asid | input | ASID_W | Current address-space tag |
| shared_ps | input | PS_W | Page size of the set-associative region |
| done | output | 1 | One-cycle completion pulse |
| res_hit | output | 1 | Search hit |
| res_ne | output | 1 | Search miss / read of absent entry |
| res_index | output | IDX_W | Hit index or fill position |
| res_ps | output | PS_W | Read page size |
| res_ehi | output | VA_W | Read entry-high |
| res_lo0 | output | LO_W | Read even low word |
| res_lo1 | output | LO_W | Read odd low word |
| res_asid | output | ASID_W | Read tag |

## Verification
Every operation takes effect at the edge that accepts it, so `done` and all result ports are due exactly one cycle after `op_valid` is sampled in ST_IDLE. Each bench task raises `op_valid` at a falling edge, drops it at the next falling edge, and reads the results at that moment, half a cycle after the accept edge. Effects on storage are checked through a later search or read, never through internal state. The acceptance rule is tested by keeping `op_valid` high across the `done` cycle with changed operands, then reading back to confirm that the second request left no trace.

// File: rtl/hyb_tlb_pkg.sv
package hyb_tlb_pkg;

    typedef enum logic [3:0] {
        OP_SEARCH       = 4'd0,
        OP_READ         = 4'd1,
        OP_WRITE        = 4'd2,
        OP_FILL         = 4'd3,
        OP_CLEAR        = 4'd4,
        OP_INV_ALL      = 4'd5,
        OP_INV_G        = 4'd6,
        OP_INV_ASID     = 4'd7,
        OP_INV_PG_ASID  = 4'd8,
        OP_INV_PG_ANY   = 4'd9
    } tlb_op_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } tlb_state_e;

endpackage

// File: rtl/hyb_tlb_lfsr.sv
module hyb_tlb_lfsr #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  TAPS = 16'hD008,
    parameter logic [W-1:0]  SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    logic fb;

    always_comb fb = ^(value & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value <= SEED;
        else        value <= {value[W-2:0], fb};
    end
endmodule

// File: rtl/hyb_tlb_cmp.sv
module hyb_tlb_cmp #(
    parameter int VA_W     = 32,
    parameter int ASID_W   = 10,
    parameter int PS_W     = 6,
    parameter int VPPN_LSB = 13,
    parameter int SET_W    = 4,
    parameter int IS_SA    = 0,
    parameter int SET_ID   = 0
) (
    input  logic [VA_W-VPPN_LSB-1:0] vppn,
    input  logic [PS_W-1:0]          ps,
    input  logic [ASID_W-1:0]        ent_asid,
    input  logic [ASID_W-1:0]        cur_asid,
    input  logic [ASID_W-1:0]        op_asid,
    input  logic [VA_W-1:0]          va,
    input  logic [PS_W-1:0]          shared_ps,
    output logic                     page_eq,
    output logic                     cur_eq,
    output logic                     op_eq,
    output logic                     in_set
);
    logic [VA_W-1:0]  ehi;
    logic [VA_W-1:0]  keep;
    logic [SET_W-1:0] va_set;

    always_comb begin
        ehi     = {vppn, {VPPN_LSB{1'b0}}};
        keep    = {VA_W{1'b1}} << (32'(ps) + 32'd1);
        page_eq = ((va ^ ehi) & keep) == '0;
        cur_eq  = (ent_asid == cur_asid);
        op_eq   = (ent_asid == op_asid);
        va_set  = SET_W'(va >> (32'(shared_ps) + 32'd1));
        in_set  = (IS_SA == 0) || (va_set == SET_W'(SET_ID));
    end
endmodule

// File: rtl/hyb_tlb_prio.sv
module hyb_tlb_prio #(
    parameter int N     = 72,
    parameter int IDX_W = 7
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/hyb_tlb.sv
module hyb_tlb
    import hyb_tlb_pkg::*;
#(
    parameter int            VA_W      = 32,
    parameter int            ASID_W    = 10,
    parameter int            PS_W      = 6,
    parameter int            LO_W      = 32,
    parameter int            G_BIT     = 6,
    parameter int            VPPN_LSB  = 13,
    parameter int            WAYS      = 4,
    parameter int            SETS      = 16,
    parameter int            FA_N      = 8,
    parameter int            LFSR_W    = 16,
    parameter logic [15:0]   LFSR_TAPS = 16'hD008,
    parameter logic [15:0]   LFSR_SEED = 16'hACE1,
    parameter int            IDX_W     = $clog2(WAYS * SETS + FA_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [IDX_W-1:0]  op_index,
    input  logic [VA_W-1:0]   op_va,
    input  logic [PS_W-1:0]   op_ps,
    input  logic              op_ne,
    input  logic [LO_W-1:0]   op_lo0,
    input  logic [LO_W-1:0]   op_lo1,
    input  logic [ASID_W-1:0] op_asid,
    input  logic              op_g,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [PS_W-1:0]   shared_ps,
    output logic              done,
    output logic              res_hit,
    output logic              res_ne,
    output logic [IDX_W-1:0]  res_index,
    output logic [PS_W-1:0]   res_ps,
    output logic [VA_W-1:0]   res_ehi,
    output logic [LO_W-1:0]   res_lo0,
    output logic [LO_W-1:0]   res_lo1,
    output logic [ASID_W-1:0] res_asid
);
    localparam int SA_N   = WAYS * SETS;
    localparam int N_ALL  = SA_N + FA_N;
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int FA_IW  = (FA_N > 1) ? $clog2(FA_N) : 1;
    localparam int VPPN_W = VA_W - VPPN_LSB;

    // ---------------- storage ----------------
    logic [N_ALL-1:0]   e_q;
    logic [VPPN_W-1:0]  vppn_q [N_ALL];
    logic [ASID_W-1:0]  asid_q [N_ALL];
    logic [LO_W-1:0]    lo0_q  [N_ALL];
    logic [LO_W-1:0]    lo1_q  [N_ALL];
    logic [PS_W-1:0]    ps_q   [FA_N];

    // ---------------- controller ----------------
    tlb_state_e state_q, state_d;
    tlb_op_e    op;
    logic       accept;

    always_comb op = tlb_op_e'(op_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_valid) state_d = ST_DONE;   // accept
            ST_DONE: state_d = ST_IDLE;                 // retire
        endcase
    end

    always_comb begin
        accept = (state_q == ST_IDLE) && op_valid;
        done   = (state_q == ST_DONE);
    end

    // ---------------- per-entry comparators ----------------
    logic [PS_W-1:0] eff_ps [N_ALL];
    logic [N_ALL-1:0] page_eq, cur_eq, op_eq, in_set, g_v;

    for (genvar i = 0; i < N_ALL; i++) begin : g_ent
        if (i < SA_N) begin : g_sa
            assign eff_ps[i] = shared_ps;
        end else begin : g_fa
            assign eff_ps[i] = ps_q[i - SA_N];
        end
        assign g_v[i] = lo0_q[i][G_BIT];

        hyb_tlb_cmp #(
            .VA_W(VA_W), .ASID_W(ASID_W), .PS_W(PS_W), .VPPN_LSB(VPPN_LSB),
            .SET_W(SET_W), .IS_SA((i < SA_N) ? 1 : 0), .SET_ID(i % SETS)
        ) u_cmp (
            .vppn(vppn_q[i]), .ps(eff_ps[i]), .ent_asid(asid_q[i]),
            .cur_asid(cur_asid), .op_asid(op_asid), .va(op_va),
            .shared_ps(shared_ps), .page_eq(page_eq[i]), .cur_eq(cur_eq[i]),
            .op_eq(op_eq[i]), .in_set(in_set[i])
        );
    end

    // ---------------- search ----------------
    logic [N_ALL-1:0] srch_v;
    logic             srch_found;
    logic [IDX_W-1:0] srch_idx;

    always_comb srch_v = e_q & page_eq & in_set & (g_v | cur_eq);

    hyb_tlb_prio #(.N(N_ALL), .IDX_W(IDX_W)) u_prio (
        .req(srch_v), .found(srch_found), .idx(srch_idx)
    );

    // ---------------- random fill position ----------------
    logic [LFSR_W-1:0] rnd;
    logic [SET_W-1:0]  fill_set;
    logic [IDX_W-1:0]  fill_idx;

    hyb_tlb_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .value(rnd)
    );

    always_comb begin
        fill_set = SET_W'(op_va >> (32'(shared_ps) + 32'd1));
        if (op_ps == shared_ps)
            fill_idx = IDX_W'((32'(rnd) % WAYS) * SETS + 32'(fill_set));
        else
            fill_idx = IDX_W'(SA_N + (32'(rnd) % FA_N));
    end

    // ---------------- load and kill vectors ----------------
    logic             idx_ok;
    logic             load_en;
    logic [IDX_W-1:0] load_idx;
    logic [N_ALL-1:0] load_v, kill_v, clr_zone;

    always_comb begin
        idx_ok   = 32'(op_index) < N_ALL;
        load_en  = accept && ((op == OP_WRITE && !op_ne && idx_ok) || op == OP_FILL);
        load_idx = (op == OP_FILL) ? fill_idx : op_index;
        load_v   = '0;
        kill_v   = '0;
        clr_zone = '0;
        for (int i = 0; i < N_ALL; i++) begin
            if (load_en && 32'(load_idx) == i) load_v[i] = 1'b1;
            if (32'(op_index) < SA_N)
                clr_zone[i] = (i < SA_N) && ((i % SETS) == (32'(op_index) % SETS));
            else if (idx_ok)
                clr_zone[i] = (i >= SA_N);
            case (op)
                OP_WRITE:       kill_v[i] = op_ne && (32'(op_index) == i);
                OP_CLEAR:       kill_v[i] = clr_zone[i] && !g_v[i] && cur_eq[i];
                OP_INV_ALL:     kill_v[i] = 1'b1;
                OP_INV_G:       kill_v[i] = (g_v[i] == op_g);
                OP_INV_ASID:    kill_v[i] = !g_v[i] && op_eq[i];
                OP_INV_PG_ASID: kill_v[i] = e_q[i] && !g_v[i] && op_eq[i] && page_eq[i];
                OP_INV_PG_ANY:  kill_v[i] = e_q[i] && (g_v[i] || op_eq[i]) && page_eq[i];
                default:        kill_v[i] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      e_q <= '0;
        else if (accept) e_q <= (e_q & ~kill_v) | load_v;
    end

    always_ff @(posedge clk) begin
        if (load_en) begin
            vppn_q[load_idx] <= op_va[VA_W-1:VPPN_LSB];
            asid_q[load_idx] <= cur_asid;
            lo0_q[load_idx]  <= op_lo0;
            lo1_q[load_idx]  <= op_lo1;
            if (32'(load_idx) >= SA_N)
                ps_q[FA_IW'(32'(load_idx) - SA_N)] <= op_ps;
        end
    end

    // ---------------- results ----------------
    logic [IDX_W-1:0] rd_idx;
    always_comb rd_idx = idx_ok ? op_index : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hit   <= 1'b0;
            res_ne    <= 1'b0;
            res_index <= '0;
            res_ps    <= '0;
            res_ehi   <= '0;
            res_lo0   <= '0;
            res_lo1   <= '0;
            res_asid  <= '0;
        end else if (accept) begin
            res_hit   <= 1'b0;
            res_ne    <= 1'b0;
            res_index <= '0;
            res_ps    <= '0;
            res_ehi   <= '0;
            res_lo0   <= '0;
            res_lo1   <= '0;
            res_asid  <= '0;
            case (op)
                OP_SEARCH: begin
                    res_hit   <= srch_found;
                    res_ne    <= !srch_found;
                    res_index <= srch_found ? srch_idx : '0;
                end
                OP_READ: begin
                    if (idx_ok && e_q[rd_idx]) begin
                        res_ps   <= eff_ps[rd_idx];
                        res_ehi  <= {vppn_q[rd_idx], {VPPN_LSB{1'b0}}};
                        res_lo0  <= lo0_q[rd_idx];
                        res_lo1  <= lo1_q[rd_idx];
                        res_asid <= asid_q[rd_idx];
                    end else begin
                        res_ne <= 1'b1;
                    end
                end
                OP_FILL:  res_index <= fill_idx;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/hyb_tlb_chk.sv
module hyb_tlb_chk #(
    parameter int VA_W   = 32,
    parameter int ASID_W = 10,
    parameter int PS_W   = 6,
    parameter int LO_W   = 32,
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int FA_N   = 8,
    parameter int IDX_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [PS_W-1:0]   op_ps,
    input logic [PS_W-1:0]   shared_ps,
    input logic              done,
    input logic              res_hit,
    input logic              res_ne,
    input logic [IDX_W-1:0]  res_index,
    input logic [PS_W-1:0]   res_ps,
    input logic [VA_W-1:0]   res_ehi,
    input logic [LO_W-1:0]   res_lo0,
    input logic [LO_W-1:0]   res_lo1,
    input logic [ASID_W-1:0] res_asid
);
    localparam int SA_N  = WAYS * SETS;
    localparam int N_ALL = SA_N + FA_N;

    a_r14_accept_done: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !done) |=> done);

    a_r14_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r14_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done);

    a_r2_search_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(op_code) == 4'd0) |-> (res_hit != res_ne));

    a_r3_hit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(op_code) == 4'd0 && res_hit) |-> (32'(res_index) < N_ALL));

    a_r6_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(op_code) == 4'd1 && res_ne) |->
        (res_lo0 == '0 && res_lo1 == '0 && res_ehi == '0 && res_asid == '0 && res_ps == '0));

    a_r7_fill_sa: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(op_code) == 4'd3 && $past(op_ps) == $past(shared_ps)) |->
        (32'(res_index) < SA_N));

    a_r7_fill_fa: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(op_code) == 4'd3 && $past(op_ps) != $past(shared_ps)) |->
        (32'(res_index) >= SA_N && 32'(res_index) < N_ALL));
endmodule

bind hyb_tlb hyb_tlb_chk #(
    .VA_W(VA_W), .ASID_W(ASID_W), .PS_W(PS_W), .LO_W(LO_W),
    .WAYS(WAYS), .SETS(SETS), .FA_N(FA_N), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_ps(op_ps), .shared_ps(shared_ps), .done(done), .res_hit(res_hit),
    .res_ne(res_ne), .res_index(res_index), .res_ps(res_ps), .res_ehi(res_ehi),
    .res_lo0(res_lo0), .res_lo1(res_lo1), .res_asid(res_asid)
);

// File: tb/tb_hyb_tlb.sv
module tb_hyb_tlb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [6:0]  op_index;
    logic [31:0] op_va;
    logic [5:0]  op_ps;
    logic        op_ne;
    logic [31:0] op_lo0, op_lo1;
    logic [9:0]  op_asid;
    logic        op_g;
    logic [9:0]  cur_asid;
    logic [5:0]  shared_ps;
    logic        done, res_hit, res_ne;
    logic [6:0]  res_index;
    logic [5:0]  res_ps;
    logic [31:0] res_ehi, res_lo0, res_lo1;
    logic [9:0]  res_asid;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    hyb_tlb dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_index(op_index), .op_va(op_va), .op_ps(op_ps), .op_ne(op_ne),
        .op_lo0(op_lo0), .op_lo1(op_lo1), .op_asid(op_asid), .op_g(op_g),
        .cur_asid(cur_asid), .shared_ps(shared_ps), .done(done),
        .res_hit(res_hit), .res_ne(res_ne), .res_index(res_index),
        .res_ps(res_ps), .res_ehi(res_ehi), .res_lo0(res_lo0),
        .res_lo1(res_lo1), .res_asid(res_asid)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; op_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse();
        @(negedge clk); op_valid = 1'b1;
        @(negedge clk); op_valid = 1'b0;
    endtask

    task automatic wr(int idx, logic [31:0] va, logic [5:0] ps, logic [31:0] lo0,
                      logic [31:0] lo1, logic [9:0] asid, logic ne);
        op_code = 4'd2; op_index = 7'(idx); op_va = va; op_ps = ps;
        op_lo0 = lo0; op_lo1 = lo1; cur_asid = asid; op_ne = ne;
        pulse();
    endtask

    task automatic rd(int idx);
        op_code = 4'd1; op_index = 7'(idx); pulse();
    endtask

    task automatic srch(logic [31:0] va, logic [9:0] asid);
        op_code = 4'd0; op_va = va; cur_asid = asid; pulse();
    endtask

    task automatic inv(logic [3:0] code, logic g, logic [9:0] asid, logic [31:0] va);
        op_code = code; op_g = g; op_asid = asid; op_va = va; pulse();
    endtask

    task automatic chk_ne(string req, int idx, logic exp);
        rd(idx);
        chk(req, $sformatf("absent[%0d]", idx), res_ne, exp);
    endtask

    task automatic chk_hit(string req, logic [31:0] va, logic [9:0] asid, logic hit, int idx);
        srch(va, asid);
        chk(req, $sformatf("hit va=%0h", va), res_hit, hit);
        if (hit) chk(req, $sformatf("index va=%0h", va), res_index, 64'(idx));
    endtask

    // R1
    task automatic t_reset();
        do_reset();
        chk("R1", "done after reset", done, 1'b0);
        chk_hit("R1", 32'h14000, 10'd0, 1'b0, 0);
        chk_ne("R1", 0, 1'b1);
        chk_ne("R1", 70, 1'b1);
    endtask

    // R5, R6
    task automatic t_write_read();
        do_reset();
        wr(5, 32'h14ABC, 6'd20, 32'h11, 32'h22, 10'd3, 1'b0);
        rd(5);
        chk("R6", "sa ne", res_ne, 1'b0);
        chk("R6", "sa ps", res_ps, 6'd13);
        chk("R5", "sa ehi", res_ehi, 32'h14000);
        chk("R5", "sa lo0", res_lo0, 32'h11);
        chk("R5", "sa lo1", res_lo1, 32'h22);
        chk("R5", "sa asid", res_asid, 10'd3);
        wr(66, 32'h00C00000, 6'd21, 32'h33, 32'h44, 10'd7, 1'b0);
        rd(66);
        chk("R5", "fa ps", res_ps, 6'd21);
        chk("R6", "fa ehi", res_ehi, 32'h00C00000);
        chk("R6", "fa asid", res_asid, 10'd7);
        wr(5, 32'h0, 6'd0, 32'h0, 32'h0, 10'd3, 1'b1);
        rd(5);
        chk("R5", "removed ne", res_ne, 1'b1);
        chk("R6", "absent lo0", res_lo0, 32'h0);
        chk("R6", "absent ehi", res_ehi, 32'h0);
        chk("R6", "absent asid", res_asid, 10'd0);
        chk("R6", "absent ps", res_ps, 6'd0);
    endtask

    // R2, R4
    task automatic t_search();
        do_reset();
        wr(5, 32'h14000, 6'd0, 32'h01, 32'h0, 10'd3, 1'b0);
        chk_hit("R2", 32'h15FFF, 10'd3, 1'b1, 5);
        chk_hit("R2", 32'h14000, 10'd4, 1'b0, 0);
        chk_hit("R2", 32'h18000, 10'd3, 1'b0, 0);
        wr(21, 32'h54000, 6'd0, 32'h40, 32'h0, 10'd3, 1'b0);
        chk_hit("R2", 32'h54000, 10'd9, 1'b1, 21);
        wr(6, 32'h94000, 6'd0, 32'h0, 32'h0, 10'd3, 1'b0);
        chk_hit("R4", 32'h94000, 10'd3, 1'b0, 0);
        wr(5, 32'h0, 6'd0, 32'h0, 32'h0, 10'd3, 1'b1);
        chk_hit("R2", 32'h14000, 10'd3, 1'b0, 0);
        wr(66, 32'h00C00000, 6'd21, 32'h0, 32'h0, 10'd3, 1'b0);
        chk_hit("R4", 32'h00D23456, 10'd3, 1'b1, 66);
        chk_hit("R4", 32'h01000000, 10'd3, 1'b0, 0);
    endtask

    // R3
    task automatic t_priority();
        do_reset();
        wr(37, 32'h14000, 6'd0, 32'h0, 32'h0, 10'd3, 1'b0);
        wr(64, 32'h14000, 6'd13, 32'h0, 32'h0, 10'd3, 1'b0);
        chk_hit("R3", 32'h14000, 10'd3, 1'b1, 37);
        wr(5, 32'h14000, 6'd0, 32'h0, 32'h0, 10'd3, 1'b0);
        chk_hit("R3", 32'h14000, 10'd3, 1'b1, 5);
        wr(5, 32'h0, 6'd0, 32'h0, 32'h0, 10'd3, 1'b1);
        wr(37, 32'h0, 6'd0, 32'h0, 32'h0, 10'd3, 1'b1);
        chk_hit("R3", 32'h14000, 10'd3, 1'b1, 64);
    endtask

    // R7
    task automatic t_fill();
        logic [6:0] fi, fj;
        do_reset();
        op_code = 4'd3; op_va = 32'h3C000; op_ps = 6'd13;
        op_lo0 = 32'h5; op_lo1 = 32'h6; cur_asid = 10'd2;
        pulse();
        fi = res_index;
        chk("R7", "sa fill region", 64'(fi < 7'd64), 1);
        chk("R7", "sa fill set", 64'(fi % 16), 15);
        chk_hit("R7", 32'h3C000, 10'd2, 1'b1, int'(fi));
        rd(int'(fi));
        chk("R7", "sa fill lo0", res_lo0, 32'h5);
        op_code = 4'd3; op_va = 32'h00800000; op_ps = 6'd21; cur_asid = 10'd2;
        pulse();
        fj = res_index;
        chk("R7", "fa fill region", 64'(fj >= 7'd64 && fj < 7'd72), 1);
        rd(int'(fj));
        chk("R7", "fa fill ps", res_ps, 6'd21);
        chk_hit("R7", 32'h00800000, 10'd2, 1'b1, int'(fj));
    endtask

    // R8
    task automatic t_clear();
        do_reset();
        wr(5,  32'h14000,    6'd0,  32'h0,  32'h0, 10'd3, 1'b0);
        wr(21, 32'h54000,    6'd0,  32'h40, 32'h0, 10'd3, 1'b0);
        wr(37, 32'h94000,    6'd0,  32'h0,  32'h0, 10'd4, 1'b0);
        wr(6,  32'h18000,    6'd0,  32'h0,  32'h0, 10'd3, 1'b0);
        wr(64, 32'h00200000, 6'd13, 32'h0,  32'h0, 10'd3, 1'b0);
        wr(65, 32'h00400000, 6'd13, 32'h0,  32'h0, 10'd3, 1'b0);
        op_code = 4'd4; op_index = 7'd53; cur_asid = 10'd3; pulse();
        chk_ne("R8", 5, 1'b1);
        chk_ne("R8", 21, 1'b0);
        chk_ne("R8", 37, 1'b0);
        chk_ne("R8", 6, 1'b0);
        chk_ne("R8", 64, 1'b0);
        op_code = 4'd4; op_index = 7'd100; cur_asid = 10'd4; pulse();
        chk_ne("R8", 37, 1'b0);
        op_code = 4'd4; op_index = 7'd66; cur_asid = 10'd3; pulse();
        chk_ne("R8", 64, 1'b1);
        chk_ne("R8", 65, 1'b1);
        chk_ne("R8", 6, 1'b0);
    endtask

    task automatic populate();
        do_reset();
        wr(5,  32'h14000,    6'd0,  32'h0,  32'h0, 10'd3, 1'b0);
        wr(21, 32'h54000,    6'd0,  32'h40, 32'h0, 10'd3, 1'b0);
        wr(37, 32'h94000,    6'd0,  32'h0,  32'h0, 10'd4, 1'b0);
        wr(64, 32'h14000,    6'd13, 32'h0,  32'h0, 10'd3, 1'b0);
        wr(65, 32'h00C00000, 6'd21, 32'h40, 32'h0, 10'd4, 1'b0);
    endtask

    // R9..R13
    task automatic t_inv();
        populate();
        inv(4'd5, 1'b0, 10'd0, 32'h0);
        chk_ne("R9", 5, 1'b1);  chk_ne("R9", 21, 1'b1); chk_ne("R9", 65, 1'b1);

        populate();
        inv(4'd6, 1'b1, 10'd0, 32'h0);
        chk_ne("R10", 21, 1'b1); chk_ne("R10", 65, 1'b1);
        chk_ne("R10", 5, 1'b0);  chk_ne("R10", 37, 1'b0); chk_ne("R10", 64, 1'b0);

        populate();
        inv(4'd7, 1'b0, 10'd3, 32'h0);
        chk_ne("R11", 5, 1'b1);  chk_ne("R11", 64, 1'b1);
        chk_ne("R11", 21, 1'b0); chk_ne("R11", 37, 1'b0); chk_ne("R11", 65, 1'b0);

        populate();
        inv(4'd8, 1'b0, 10'd3, 32'h14000);
        chk_ne("R12", 5, 1'b1);  chk_ne("R12", 64, 1'b1);
        chk_ne("R12", 21, 1'b0); chk_ne("R12", 37, 1'b0);
        inv(4'd8, 1'b0, 10'd3, 32'h54000);
        chk_ne("R12", 21, 1'b0);

        populate();
        inv(4'd9, 1'b0, 10'd5, 32'h00C12345);
        chk_ne("R13", 65, 1'b1);
        chk_ne("R13", 5, 1'b0);  chk_ne("R13", 21, 1'b0); chk_ne("R13", 37, 1'b0);
        inv(4'd9, 1'b0, 10'd4, 32'h94000);
        chk_ne("R13", 37, 1'b1);
        chk_ne("R13", 5, 1'b0);
    endtask

    // R14
    task automatic t_handshake();
        do_reset();
        op_code = 4'd2; op_index = 7'd5; op_va = 32'h14000; op_ne = 1'b0;
        cur_asid = 10'd3; op_lo0 = 32'h1; op_lo1 = 32'h0; op_ps = 6'd0;
        @(negedge clk); op_valid = 1'b1;
        chk("R14", "done before accept", done, 1'b0);
        @(negedge clk);
        chk("R14", "done after accept", done, 1'b1);
        op_index = 7'd6;
        @(negedge clk); op_valid = 1'b0;
        chk("R14", "held request ignored", done, 1'b0);
        chk_ne("R14", 6, 1'b1);
        chk_ne("R14", 5, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd0; op_index = '0;
        op_va = '0; op_ps = '0; op_ne = 1'b0; op_lo0 = '0; op_lo1 = '0;
        op_asid = '0; op_g = 1'b0; cur_asid = '0; shared_ps = 6'd13;
        t_reset();
        t_write_read();
        t_search();
        t_priority();
        t_fill();
        t_clear();
        t_inv();
        t_handshake();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule